// File: doc/BRIEF.md
# Single-Clock FIFO with Selectable Read Timing and Programmable Threshold Flags

This block is a single-clock FIFO with a 36-bit data path and a parameterized depth. A mode bit is captured during master reset and selects one of two read behaviours:

- **Standard timing.** A read request moves the oldest word onto the output register at the next edge. The two status outputs then mean "data stored" and "space free".
- **Fall-through timing.** The oldest word is presented on the output without any request. The status outputs then mean "output word valid" and "input can accept".

Two threshold flags report nearly-empty and nearly-full conditions. Each threshold is an offset. At master reset both offsets take one of five preset values chosen by a code. They can be reloaded later, either one at a time as whole words from the data bus or as a single serial stream of bits. A partial reset empties the FIFO but keeps the mode and the offsets. A retransmit request rewinds the read side to the first word stored since the last reset.

Top module: `cfg_fifo`

## Requirements
- R1: A master reset (`rst_n` low at a rising edge) empties the FIFO and captures the timing mode from `cfg_fwft` (0 = standard, 1 = fall-through). Afterwards `rd_avail` is 0, `wr_room` is 1 and `almost_empty` is 1.
- R2: In standard mode, `rd_en` with `rd_avail`=1 puts the oldest stored word on `rd_data` after that edge, and words leave in write order. `rd_avail` is 1 while at least one word is stored. `wr_room` is 1 while fewer than 2^ADDR_W words are stored.
- R3: A write while `wr_room`=0 and a read while no word is available are ignored, even when the other request is served on the same edge. An ignored read leaves `rd_data` unchanged.
- R4: A write and a read on the same edge both take effect when each is allowed on its own, so the stored count is unchanged.
- R5: In fall-through mode, a word written to an empty FIFO appears on `rd_data` with `rd_avail`=1 at the second rising edge after the write edge, without any `rd_en`. The word stays there until `rd_en` is seen with `rd_avail`=1. The FIFO holds 2^ADDR_W+1 words.
- R6: At master reset, `cfg_preset` sets both offsets: code 0 gives 8, 1 gives 16, 2 gives 64, 3 gives 256, and 4 to 7 give 1024. Each value is clipped to 2^ADDR_W.
- R7: `almost_empty` is 1 when the number of stored words is at or below the empty offset. `almost_full` is 1 when the free space is at or below the full offset. Free space is the capacity minus the stored words, and in fall-through mode the output word counts as stored.
- R8: `ld_en` loads `wr_data[OFS_W-1:0]` into the empty offset (`ld_sel`=0) or the full offset (`ld_sel`=1). The new value is in force after that edge.
- R9: `ser_en` shifts `ser_bit` in, one bit per edge. The stream is 2*OFS_W bits: the empty offset comes first, then the full offset, each most significant bit first. Both offsets keep their old values until the last bit's edge and change together at that edge.
- R10: A partial reset (`prst_n` low at an edge) empties the FIFO and keeps the timing mode and both offsets.
- R11: A `retx` pulse rewinds reading to the first word written since the last reset, so every such word is read again. This holds if no more than 2^ADDR_W words were written since that reset. Reads and writes requested on the `retx` edge are ignored. In fall-through mode the output word is dropped, and the first word is presented again one edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Master reset, synchronous, active low |
| prst_n | input | 1 | Partial reset, synchronous, active low |
| cfg_fwft | input | 1 | Timing mode captured at master reset (1 = fall-through) |
| cfg_preset | input | 3 | Offset preset code captured at master reset |
| wr_en | input | 1 | Write request |
| wr_data | input | DATA_W | Write data; low bits also carry parallel offset loads |
| rd_en | input | 1 | Read request |
| retx | input | 1 | Retransmit request |
| ld_en | input | 1 | Parallel offset load strobe |
| ld_sel | input | 1 | Parallel load target: 0 = empty offset, 1 = full offset |
| ser_en | input | 1 | Serial offset shift enable |
| ser_bit | input | 1 | Serial offset data bit |
| rd_data | output | DATA_W | Read data |
| rd_avail | output | 1 | Standard: data stored; fall-through: output word valid |
| wr_room | output | 1 | Write will be accepted |
| almost_empty | output | 1 | Stored words at or below the empty offset |
| almost_full | output | 1 | Free space at or below the full offset |

## Verification
The standard read path is tried at every fill level from empty to full. At each level the flags are checked, the data is drained in order, a write is attempted when full and a read when empty. This separates off-by-one errors in the count from errors in the pointers. The preset codes are all walked, and the offsets are reloaded through both programming paths. At each level the flags are compared against thresholds computed in the bench, which tells apart a wrong preset, a wrong bit order and an offset that changes too early. Streams of simultaneous writes and reads are run against an empty FIFO, a FIFO with some data, and a full FIFO, to check which requests are served. The fall-through tests cover the extra output word, presentation without any request, and retransmit.

// File: rtl/cfg_fifo_pkg.sv
`timescale 1ns/1ps
// Shared types and helpers for the configurable-timing FIFO.
package cfg_fifo_pkg;

    // Read timing mode captured at master reset.
    typedef enum logic {
        MODE_STD  = 1'b0,
        MODE_FWFT = 1'b1
    } fifo_mode_e;

    // Preset offset selected by a code: 0..3 pick 8, 16, 64, 256; 4..7 pick 1024.
    function automatic int preset_value(input logic [2:0] code);
        case (code)
            3'd0:    return 8;
            3'd1:    return 16;
            3'd2:    return 64;
            3'd3:    return 256;
            default: return 1024;
        endcase
    endfunction

endpackage

// File: rtl/cfg_fifo_cfg.sv
`timescale 1ns/1ps
// Configuration holder: timing mode and the two threshold offsets.
// The mode and the preset offsets are captured while master reset is low.
// A partial reset only aborts a serial stream in progress.
// Assumes OFS_W >= ADDR_W+1, so that a clipped preset fits.
module cfg_fifo_cfg
    import cfg_fifo_pkg::*;
#(
    parameter int ADDR_W = 11,
    parameter int OFS_W  = ADDR_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             prst_n,
    input  logic             cfg_fwft,
    input  logic [2:0]       cfg_preset,
    input  logic             ld_en,
    input  logic             ld_sel,
    input  logic [OFS_W-1:0] ld_val,
    input  logic             ser_en,
    input  logic             ser_bit,
    output fifo_mode_e       mode,
    output logic [OFS_W-1:0] ae_off,
    output logic [OFS_W-1:0] af_off
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam int SH_W  = 2 * OFS_W;
    localparam int BC_W  = $clog2(SH_W);

    logic [SH_W-1:0] shreg;
    logic [SH_W-1:0] shnext;
    logic [BC_W-1:0] bitcnt;
    logic            last_bit;

    // Clip a preset to the depth and size it to the offset width.
    function automatic logic [OFS_W-1:0] clip_preset(input logic [2:0] code);
        int v;
        v = preset_value(code);
        if (v > DEPTH) v = DEPTH;
        return OFS_W'(v);
    endfunction

    // Next serial shift value and end-of-stream detect.
    always_comb begin
        shnext   = {shreg[SH_W-2:0], ser_bit};
        last_bit = (bitcnt == BC_W'(SH_W - 1));
    end

    // Timing mode register, loaded only during master reset.
    always_ff @(posedge clk) begin
        if (!rst_n) mode <= fifo_mode_e'(cfg_fwft);
    end

    // Offset registers with the preset, serial and parallel load paths.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ae_off <= clip_preset(cfg_preset);
            af_off <= clip_preset(cfg_preset);
            shreg  <= '0;
            bitcnt <= '0;
        end else if (!prst_n) begin
            shreg  <= '0;
            bitcnt <= '0;
        end else if (ser_en) begin
            shreg <= shnext;
            if (last_bit) begin
                ae_off <= shnext[SH_W-1:OFS_W];
                af_off <= shnext[OFS_W-1:0];
                bitcnt <= '0;
            end else begin
                bitcnt <= bitcnt + BC_W'(1);
            end
        end else if (ld_en) begin
            if (ld_sel) af_off <= ld_val;
            else        ae_off <= ld_val;
        end
    end

endmodule

// File: rtl/cfg_fifo_core.sv
`timescale 1ns/1ps
// Storage ring with write and read pointers, a word count, and a count of
// words read since the last rewind.
// Assumes the caller never pushes when full, never pops when empty, and
// never pushes or pops on a rewind cycle.
module cfg_fifo_core #(
    parameter int DATA_W = 36,
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prst_n,
    input  logic              push,
    input  logic              pop,
    input  logic              rewind,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] head,
    output logic [ADDR_W:0]   cnt
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam int CW    = ADDR_W + 1;

    logic [DATA_W-1:0] mem [DEPTH];
    logic [ADDR_W-1:0] wptr;
    logic [ADDR_W-1:0] rptr;
    logic [CW-1:0]     rd_since;
    logic              clr;

    // Either reset clears the pointers and counts.
    always_comb clr = !rst_n || !prst_n;

    // Storage write port.
    always_ff @(posedge clk) begin
        if (push) mem[wptr] <= wdata;
    end

    // Oldest word, read without a clock.
    always_comb head = mem[rptr];

    // Write pointer update.
    always_ff @(posedge clk) begin
        if (clr)       wptr <= '0;
        else if (push) wptr <= wptr + ADDR_W'(1);
    end

    // Read pointer update; a rewind returns it to the first stored word.
    always_ff @(posedge clk) begin
        if (clr)         rptr <= '0;
        else if (rewind) rptr <= '0;
        else if (pop)    rptr <= rptr + ADDR_W'(1);
    end

    // Stored count; a rewind gives back every word read since the last reset.
    always_ff @(posedge clk) begin
        if (clr)         cnt <= '0;
        else if (rewind) cnt <= cnt + rd_since;
        else             cnt <= cnt + CW'(push) - CW'(pop);
    end

    // Words read since the last reset or rewind.
    always_ff @(posedge clk) begin
        if (clr || rewind) rd_since <= '0;
        else if (pop)      rd_since <= rd_since + CW'(1);
    end

endmodule

// File: rtl/cfg_fifo_ostage.sv
`timescale 1ns/1ps
// Output stage. In standard mode it loads the read register on a request.
// In fall-through mode it keeps the oldest word presented and refills it
// by itself.
// Assumes core_cnt is the core's stored count and head is its oldest word.
module cfg_fifo_ostage
    import cfg_fifo_pkg::*;
#(
    parameter int DATA_W = 36,
    parameter int CW     = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prst_n,
    input  fifo_mode_e        mode,
    input  logic              rd_en,
    input  logic              rewind,
    input  logic [CW-1:0]     core_cnt,
    input  logic [DATA_W-1:0] head,
    output logic              pop,
    output logic [DATA_W-1:0] rd_data,
    output logic              out_flag,
    output logic [CW-1:0]     total
);
    logic is_fwft;
    logic core_has;
    logic ov;

    // Decide when a word moves from the core into the output register.
    always_comb begin
        is_fwft  = (mode == MODE_FWFT);
        core_has = (core_cnt != '0);
        if (is_fwft) pop = core_has && (!ov || rd_en) && !rewind;
        else         pop = rd_en && core_has && !rewind;
    end

    // Output register and its valid bit (the valid bit is used only in fall-through).
    always_ff @(posedge clk) begin
        if (!rst_n || !prst_n) begin
            rd_data <= '0;
            ov      <= 1'b0;
        end else if (rewind) begin
            ov <= 1'b0;
        end else if (pop) begin
            rd_data <= head;
            ov      <= is_fwft;
        end else if (rd_en && ov) begin
            ov <= 1'b0;
        end
    end

    // Read-side flag and stored total (the output word counts in fall-through).
    always_comb begin
        out_flag = is_fwft ? ov : core_has;
        total    = core_cnt + CW'(ov);
    end

endmodule

// File: rtl/cfg_fifo.sv
`timescale 1ns/1ps
// Single-clock FIFO with selectable standard or fall-through read timing,
// threshold flags with preset or programmed offsets, partial reset and
// retransmit.
// Assumes the user keeps writes since the last reset within the depth when
// relying on retransmit.
module cfg_fifo
    import cfg_fifo_pkg::*;
#(
    parameter int DATA_W = 36,
    parameter int ADDR_W = 11,
    parameter int OFS_W  = ADDR_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prst_n,
    input  logic              cfg_fwft,
    input  logic [2:0]        cfg_preset,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic              retx,
    input  logic              ld_en,
    input  logic              ld_sel,
    input  logic              ser_en,
    input  logic              ser_bit,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_avail,
    output logic              wr_room,
    output logic              almost_empty,
    output logic              almost_full
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam int CW    = ADDR_W + 1;
    localparam int CMP_W = (OFS_W > CW) ? OFS_W : CW;

    fifo_mode_e        mode;
    logic [OFS_W-1:0]  ae_off;
    logic [OFS_W-1:0]  af_off;
    logic [CW-1:0]     core_cnt;
    logic [CW-1:0]     total;
    logic [CW-1:0]     cap;
    logic [CW-1:0]     free_sp;
    logic [DATA_W-1:0] head;
    logic              push;
    logic              pop;

    cfg_fifo_cfg #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .prst_n     (prst_n),
        .cfg_fwft   (cfg_fwft),
        .cfg_preset (cfg_preset),
        .ld_en      (ld_en),
        .ld_sel     (ld_sel),
        .ld_val     (wr_data[OFS_W-1:0]),
        .ser_en     (ser_en),
        .ser_bit    (ser_bit),
        .mode       (mode),
        .ae_off     (ae_off),
        .af_off     (af_off)
    );

    // Accept a write when the core has space and no rewind is pending.
    always_comb begin
        wr_room = (core_cnt != CW'(DEPTH));
        push    = wr_en && wr_room && !retx;
    end

    cfg_fifo_core #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_core (
        .clk    (clk),
        .rst_n  (rst_n),
        .prst_n (prst_n),
        .push   (push),
        .pop    (pop),
        .rewind (retx),
        .wdata  (wr_data),
        .head   (head),
        .cnt    (core_cnt)
    );

    cfg_fifo_ostage #(.DATA_W(DATA_W), .CW(CW)) u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .prst_n   (prst_n),
        .mode     (mode),
        .rd_en    (rd_en),
        .rewind   (retx),
        .core_cnt (core_cnt),
        .head     (head),
        .pop      (pop),
        .rd_data  (rd_data),
        .out_flag (rd_avail),
        .total    (total)
    );

    // Threshold flags against the capacity of the current mode.
    always_comb begin
        cap          = CW'(DEPTH) + CW'(mode == MODE_FWFT);
        free_sp      = cap - total;
        almost_empty = CMP_W'(total)   <= CMP_W'(ae_off);
        almost_full  = CMP_W'(free_sp) <= CMP_W'(af_off);
    end

endmodule

// File: rtl/cfg_fifo_chk.sv
`timescale 1ns/1ps
// Protocol checker for cfg_fifo, attached with bind. It observes the ports
// and the captured mode only.
module cfg_fifo_chk
    import cfg_fifo_pkg::*;
#(
    parameter int DATA_W = 36
) (
    input logic              clk,
    input logic              rst_n,
    input logic              prst_n,
    input logic              wr_en,
    input logic              rd_en,
    input logic              retx,
    input logic [DATA_W-1:0] rd_data,
    input logic              rd_avail,
    input logic              wr_room,
    input logic              almost_empty,
    input fifo_mode_e        mode
);
    // R3: a write into a full FIFO with no read leaves it full.
    a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        prst_n && !wr_room && wr_en && !rd_en && !retx |=> !wr_room);

    // R3: a read of an empty FIFO in standard mode changes nothing.
    a_r3_empty_read: assert property (@(posedge clk) disable iff (!rst_n)
        mode == MODE_STD && prst_n && !rd_avail && rd_en && !wr_en && !retx
        |=> !rd_avail && $stable(rd_data));

    // R4: a served write and read on one edge keep data available.
    a_r4_same_edge: assert property (@(posedge clk) disable iff (!rst_n)
        mode == MODE_STD && prst_n && rd_avail && wr_room && wr_en && rd_en && !retx
        |=> rd_avail);

    // R5: a presented fall-through word holds until it is read.
    a_r5_fwft_hold: assert property (@(posedge clk) disable iff (!rst_n)
        mode == MODE_FWFT && prst_n && rd_avail && !rd_en && !retx
        |=> rd_avail && $stable(rd_data));

    // R10: a partial reset empties the FIFO.
    a_r10_prst_empty: assert property (@(posedge clk) disable iff (!rst_n)
        !prst_n |=> !rd_avail && wr_room && almost_empty);

    // R10: a partial reset keeps the timing mode.
    a_r10_mode_kept: assert property (@(posedge clk) disable iff (!rst_n)
        !prst_n |=> $stable(mode));

    // R11: a retransmit in fall-through mode drops the presented word.
    a_r11_retx_drop: assert property (@(posedge clk) disable iff (!rst_n)
        mode == MODE_FWFT && prst_n && retx |=> !rd_avail);

endmodule

bind cfg_fifo cfg_fifo_chk #(.DATA_W(DATA_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .prst_n       (prst_n),
    .wr_en        (wr_en),
    .rd_en        (rd_en),
    .retx         (retx),
    .rd_data      (rd_data),
    .rd_avail     (rd_avail),
    .wr_room      (wr_room),
    .almost_empty (almost_empty),
    .mode         (mode)
);

// File: tb/sim_cfg_fifo.sv
`timescale 1ns/1ps
// Self-checking bench for cfg_fifo with a 16-word configuration.
module sim_cfg_fifo;
    localparam int DW  = 36;
    localparam int AW  = 4;
    localparam int OW  = 5;
    localparam int DEP = 16;
    localparam int SW  = 2 * OW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0, prst_n = 1'b1, cfg_fwft = 1'b0;
    logic [2:0]    cfg_preset = 3'd0;
    logic          wr_en = 1'b0, rd_en = 1'b0, retx = 1'b0;
    logic          ld_en = 1'b0, ld_sel = 1'b0, ser_en = 1'b0, ser_bit = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic [DW-1:0] rd_data;
    logic          rd_avail, wr_room, almost_empty, almost_full;

    int  nchk = 0, nerr = 0, wr_idx = 0, rd_idx = 0;
    bit  done = 1'b0;

    always #5 clk = ~clk;

    cfg_fifo #(.DATA_W(DW), .ADDR_W(AW), .OFS_W(OW)) u0 (
        .clk(clk), .rst_n(rst_n), .prst_n(prst_n), .cfg_fwft(cfg_fwft),
        .cfg_preset(cfg_preset), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .retx(retx), .ld_en(ld_en), .ld_sel(ld_sel),
        .ser_en(ser_en), .ser_bit(ser_bit), .rd_data(rd_data),
        .rd_avail(rd_avail), .wr_room(wr_room),
        .almost_empty(almost_empty), .almost_full(almost_full)
    );

    function automatic logic [DW-1:0] pat(input int i);
        return (36'(i) * 36'd40503) ^ 36'h9A5C31E7F;
    endfunction

    function automatic int preset_exp(input int code);
        int v;
        case (code)
            0: v = 8;
            1: v = 16;
            2: v = 64;
            3: v = 256;
            default: v = 1024;
        endcase
        return (v > DEP) ? DEP : v;
    endfunction

    task automatic chk_b(input string tag, input logic act, input logic exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s act=%0b exp=%0b", tag, act, exp);
        end
    endtask

    task automatic chk_d(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic mreset(input logic fw, input logic [2:0] code);
        rst_n = 1'b0; cfg_fwft = fw; cfg_preset = code;
        tick(); tick();
        rst_n = 1'b1; cfg_fwft = ~fw; cfg_preset = ~code;
        wr_idx = 0; rd_idx = 0;
    endtask

    task automatic preset_rst();
        prst_n = 1'b0; tick(); prst_n = 1'b1;
        wr_idx = 0; rd_idx = 0;
    endtask

    task automatic push_one();
        wr_en = 1'b1; wr_data = pat(wr_idx); tick(); wr_en = 1'b0;
        wr_idx++;
    endtask

    task automatic pop_std();
        rd_en = 1'b1; tick(); rd_en = 1'b0;
        chk_d("R2 read data order", rd_data, pat(rd_idx));
        rd_idx++;
    endtask

    task automatic ser_send(input logic [SW-1:0] v, input int first, input int last);
        for (int b = first; b <= last; b++) begin
            ser_en = 1'b1; ser_bit = v[SW-1-b]; tick();
        end
        ser_en = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            nchk++; nerr++;
            $display("FAIL watchdog act=hung exp=finished");
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    initial begin
        // R1: reset state, standard mode, preset 0.
        mreset(1'b0, 3'd0);
        chk_b("R1 rd_avail after reset", rd_avail, 1'b0);
        chk_b("R1 wr_room after reset", wr_room, 1'b1);
        chk_b("R1 almost_empty after reset", almost_empty, 1'b1);
        chk_b("R1 almost_full after reset", almost_full, 1'b0);

        // R6 and R7: every preset code, flags at every fill level.
        for (int code = 0; code < 8; code++) begin
            mreset(1'b0, 3'(code));
            for (int k = 1; k <= DEP; k++) begin
                push_one();
                chk_b("R6 R7 almost_empty vs preset", almost_empty, k <= preset_exp(code));
                chk_b("R6 R7 almost_full vs preset", almost_full, (DEP - k) <= preset_exp(code));
            end
        end

        // R2 and R3: every fill level, drained in order, overflow and underflow.
        mreset(1'b0, 3'd0);
        for (int n = 0; n <= DEP; n++) begin
            preset_rst();
            for (int k = 1; k <= n; k++) push_one();
            chk_b("R2 wr_room at fill", wr_room, n < DEP);
            chk_b("R2 rd_avail at fill", rd_avail, n > 0);
            if (n == DEP) begin
                wr_en = 1'b1; wr_data = pat(99); tick(); wr_en = 1'b0;
                chk_b("R3 write while full ignored", wr_room, 1'b0);
            end
            for (int k = 0; k < n; k++) pop_std();
            chk_b("R3 drained without extra word", rd_avail, 1'b0);
            if (n > 0) begin
                rd_en = 1'b1; tick(); rd_en = 1'b0;
                chk_d("R3 empty read leaves data", rd_data, pat(n - 1));
                chk_b("R3 empty read keeps empty", rd_avail, 1'b0);
            end
        end

        // R4: simultaneous write and read with 5 stored.
        preset_rst();
        for (int k = 0; k < 5; k++) push_one();
        for (int k = 0; k < 10; k++) begin
            wr_en = 1'b1; wr_data = pat(wr_idx); rd_en = 1'b1; tick();
            wr_idx++;
            chk_d("R4 same-edge read data", rd_data, pat(rd_idx));
            rd_idx++;
            chk_b("R4 count held", rd_avail, 1'b1);
        end
        wr_en = 1'b0; rd_en = 1'b0;
        for (int k = 0; k < 5; k++) pop_std();
        chk_b("R4 five left after stream", rd_avail, 1'b0);

        // R3: on a full FIFO, same-edge read is served and write dropped.
        preset_rst();
        for (int k = 0; k < DEP; k++) push_one();
        wr_en = 1'b1; wr_data = pat(77); rd_en = 1'b1; tick();
        wr_en = 1'b0; rd_en = 1'b0;
        chk_d("R3 full same-edge read", rd_data, pat(0));
        rd_idx = 1;
        chk_b("R3 room after full same-edge", wr_room, 1'b1);
        for (int k = 1; k < DEP; k++) pop_std();
        chk_b("R3 full write dropped", rd_avail, 1'b0);

        // R3: on an empty FIFO, same-edge write is served and read dropped.
        wr_en = 1'b1; wr_data = pat(wr_idx); rd_en = 1'b1; tick();
        wr_en = 1'b0; rd_en = 1'b0; wr_idx++;
        chk_b("R3 empty same-edge write kept", rd_avail, 1'b1);
        pop_std();

        // R8: parallel load, empty offset 3 and full offset 2.
        preset_rst();
        ld_en = 1'b1; ld_sel = 1'b0; wr_data = 36'd3; tick();
        ld_sel = 1'b1; wr_data = 36'd2; tick();
        ld_en = 1'b0;
        chk_b("R8 almost_empty at 0", almost_empty, 1'b1);
        for (int k = 1; k <= DEP; k++) begin
            push_one();
            chk_b("R8 almost_empty parallel offset", almost_empty, k <= 3);
            chk_b("R8 almost_full parallel offset", almost_full, (DEP - k) <= 2);
        end

        // R9: serial stream of empty offset 1 then full offset 5.
        preset_rst();
        ser_send({5'd1, 5'd5}, 0, SW - 2);
        for (int k = 0; k < 3; k++) push_one();
        chk_b("R9 old offset before last bit", almost_empty, 1'b1);
        ser_send({5'd1, 5'd5}, SW - 1, SW - 1);
        chk_b("R9 new empty offset after last bit", almost_empty, 1'b0);
        for (int k = 3; k < 10; k++) push_one();
        chk_b("R9 full offset at free 6", almost_full, 1'b0);
        push_one();
        chk_b("R9 new full offset at free 5", almost_full, 1'b1);

        // R10: partial reset keeps programmed offsets.
        preset_rst();
        chk_b("R10 empty after partial reset", rd_avail, 1'b0);
        chk_b("R10 room after partial reset", wr_room, 1'b1);
        push_one();
        chk_b("R10 offset kept at 1 word", almost_empty, 1'b1);
        push_one();
        chk_b("R10 offset kept at 2 words", almost_empty, 1'b0);

        // R11: standard retransmit with an ignored write on the rewind edge.
        preset_rst();
        for (int k = 0; k < 6; k++) push_one();
        for (int k = 0; k < 3; k++) pop_std();
        retx = 1'b1; wr_en = 1'b1; wr_data = pat(50); tick();
        retx = 1'b0; wr_en = 1'b0;
        rd_idx = 0;
        for (int k = 0; k < 6; k++) begin
            rd_en = 1'b1; tick(); rd_en = 1'b0;
            chk_d("R11 retransmitted word", rd_data, pat(rd_idx));
            rd_idx++;
        end
        chk_b("R11 write on rewind edge ignored", rd_avail, 1'b0);

        // R1 and R5: fall-through mode, preset 16.
        mreset(1'b1, 3'd1);
        chk_b("R1 fwft rd_avail after reset", rd_avail, 1'b0);
        chk_b("R1 fwft wr_room after reset", wr_room, 1'b1);
        push_one();
        chk_b("R5 not yet presented", rd_avail, 1'b0);
        tick();
        chk_b("R5 presented without request", rd_avail, 1'b1);
        chk_d("R5 presented word", rd_data, pat(0));

        // R5 and R7: capacity of 17 words in fall-through mode.
        preset_rst();
        for (int k = 0; k < DEP + 1; k++) begin
            chk_b("R5 room before word", wr_room, 1'b1);
            push_one();
        end
        chk_b("R5 full at 17", wr_room, 1'b0);
        chk_b("R7 fwft almost_full at full", almost_full, 1'b1);
        chk_b("R7 fwft almost_empty at 17", almost_empty, 1'b0);
        wr_en = 1'b1; wr_data = pat(88); tick(); wr_en = 1'b0;
        for (int k = 0; k < DEP + 1; k++) begin
            chk_b("R5 word valid", rd_avail, 1'b1);
            chk_d("R5 fwft order", rd_data, pat(k));
            rd_en = 1'b1; tick(); rd_en = 1'b0;
        end
        chk_b("R5 fwft drained, extra write dropped", rd_avail, 1'b0);

        // R10 and R11: fall-through mode kept through partial reset, retransmit.
        preset_rst();
        for (int k = 0; k < 4; k++) push_one();
        tick();
        chk_d("R10 fwft mode kept", rd_data, pat(0));
        for (int k = 0; k < 2; k++) begin
            chk_d("R11 fwft read before rewind", rd_data, pat(k));
            rd_en = 1'b1; tick(); rd_en = 1'b0;
        end
        retx = 1'b1; tick(); retx = 1'b0;
        chk_b("R11 fwft word dropped on rewind", rd_avail, 1'b0);
        tick();
        chk_b("R11 fwft first word back", rd_avail, 1'b1);
        chk_d("R11 fwft first word data", rd_data, pat(0));

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

endmodule